// File: doc/BRIEF.md
# Memory-Mapped Serial Port with FIFO Watermarks

This block is a byte-wide asynchronous serial port attached to a simple word-addressed register bus. Software pushes bytes into an eight-entry transmit queue. The serializer sends each byte as a start bit, eight data bits with the least significant bit first, and one or two stop bits. A receiver oversamples the incoming line and places each good byte into an eight-entry receive queue, where software reads it.

Status is not kept in separate registers. The top bit of each data register reports whether the transmit queue is full or the receive queue is empty. Two interrupt conditions compare queue occupancy against programmable thresholds, one for each direction, and a mask register gates them onto a single interrupt line. One divisor sets the oversampling tick. Sixteen ticks make one bit time, so the divisor value alone fixes the baud rate.

Top module: `mmio_uart`

## Requirements
- R1: After reset the serial output is high, the interrupt is low, and reads return 0 from the transmit data, transmit control, receive control, interrupt enable, pending and divisor registers. A read of receive data returns bit 31 set.
- R2: The registers are at byte offsets 0x00 transmit data, 0x04 receive data, 0x08 transmit control (bit 0 enable, bit 1 two stop bits, bits [18:16] threshold), 0x0C receive control (bit 0 enable, bits [18:16] threshold), 0x10 enable mask, 0x14 pending and 0x18 divisor. The writable fields read back as written.
- R3: A write to 0x00 queues bits [7:0]. A read of 0x00 returns bit 31 set while eight bytes are queued. A write while the queue is full is dropped.
- R4: A read of 0x04 with bytes queued returns the oldest byte in bits [7:0] with bit 31 clear and removes that byte. With the queue empty it returns bit 31 set.
- R5: Each sent frame is a low start bit, eight data bits LSB first and a high stop bit, with a second high stop bit when transmit control bit 1 is set. Every bit lasts 16 x (divisor + 1) clock cycles.
- R6: While the transmit enable is clear, no new frame starts. Clearing it during a frame lets that frame finish.
- R7: The receiver takes three samples around the middle of each bit and uses the majority value. It queues a byte only after a high stop bit. While the receive enable is clear it queues nothing.
- R8: A byte that arrives while the receive queue holds eight bytes is discarded, and the eight queued bytes are kept in order.
- R9: Pending bit 0 is 1 exactly while the transmit occupancy is below the transmit threshold.
- R10: Pending bit 1 is 1 exactly while the receive occupancy is above the receive threshold.
- R11: The interrupt output is the OR of the pending bits ANDed with the enable mask bits 1:0. Writes to the pending register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| serial_rx | input | 1 | Serial receive line |
| serial_tx | output | 1 | Serial transmit line |
| irq | output | 1 | Masked watermark interrupt |

## Verification
The bench checks the threshold comparisons at the edges where they change. A receive occupancy equal to the threshold must not raise the pending bit, and an empty transmit queue with a threshold of 1 must raise it. An off-by-one comparator would flip the result at exactly those points. Frames are decoded at the line and compared in order. The spacing between back-to-back frames is also measured, so a design that adds a stop bit, or ignores the setting for two stop bits, shows up as a wrong frame length. The bench also covers four cases where a byte must be dropped or a frame must not start: a write to a full transmit queue, a byte arriving at a full receive queue, a frame with a bad stop bit, and a transmit enable cleared while a frame is in flight. A design that gets any of these wrong produces an extra frame or an extra byte, and the scoreboard flags it.

// File: rtl/mmio_uart_pkg.sv
// Package: register selector, receiver states and the majority helper
// shared by the serial port modules.
package mmio_uart_pkg;

    // Word index of each register (byte address bits [4:2]).
    typedef enum logic [2:0] {
        REG_TXDATA = 3'd0,
        REG_RXDATA = 3'd1,
        REG_TXCTRL = 3'd2,
        REG_RXCTRL = 3'd3,
        REG_IE     = 3'd4,
        REG_IP     = 3'd5,
        REG_DIV    = 3'd6
    } reg_sel_e;

    localparam int unsigned WM_LSB = 16;
    localparam int unsigned WM_W   = 3;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_fifo.sv
// Module: uart_fifo
// Synchronous first-in first-out queue with an occupancy count.
// Assumes: a push while full and a pop while empty are ignored here, so
// the caller does not need to gate them. Storage is not reset.
module uart_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               dout,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];
    assign count   = cnt;

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R3 / R8: occupancy never exceeds the depth.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R8: a push into a full queue without a pop leaves the occupancy unchanged.
    a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/uart_tx_ser.sv
// Module: uart_tx_ser
// Serializer: pulls a byte from the transmit queue and sends start, eight
// data bits LSB first and one or two stop bits.
// Assumes: tick is a one-cycle pulse and OSR ticks make one bit time. The
// stop-bit setting is sampled when the frame is loaded.
module uart_tx_ser #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       txen,
    input  logic       two_stop,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       fifo_pop,
    output logic       txd
);
    localparam int TW = $clog2(OSR);

    logic          busy;
    logic [10:0]   shreg;
    logic [3:0]    bits_left;
    logic [TW-1:0] tcnt;

    // A new frame starts only when idle, enabled and data is waiting.
    assign fifo_pop = !busy && txen && !fifo_empty;

    // Frame load, bit timing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            txd       <= 1'b1;
            shreg     <= '1;
            bits_left <= '0;
            tcnt      <= '0;
        end else if (!busy) begin
            if (fifo_pop) begin
                busy      <= 1'b1;
                shreg     <= {2'b11, fifo_data, 1'b0};
                txd       <= 1'b0;
                bits_left <= two_stop ? 4'd11 : 4'd10;
                tcnt      <= '0;
            end
        end else if (tick) begin
            if (tcnt == TW'(OSR-1)) begin
                tcnt <= '0;
                if (bits_left == 4'd1) begin
                    busy <= 1'b0;
                    txd  <= 1'b1;
                end else begin
                    shreg     <= {1'b1, shreg[10:1]};
                    txd       <= shreg[1];
                    bits_left <= bits_left - 1'b1;
                end
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // R5: the line is high whenever no frame is in progress.
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R5: a frame never holds more than start + 8 data + 2 stop bits.
    a_r5_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bits_left != 4'd0 && bits_left <= 4'd11));

endmodule

// File: rtl/uart_rx_des.sv
// Module: uart_rx_des
// Deserializer: synchronizes the line, finds a falling edge, and takes a
// majority of three samples around the middle of each bit.
// Assumes: tick is a one-cycle pulse and OSR ticks make one bit time. A
// frame in progress completes even if rxen falls during it.
module uart_rx_des
    import mmio_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxen,
    input  logic       rxd,
    output logic       push,
    output logic [7:0] data
);
    localparam int TW  = $clog2(OSR);
    localparam int MID = OSR / 2;

    rx_state_e     state;
    logic [2:0]    sync;
    logic [TW-1:0] tcnt;
    logic [1:0]    samp;
    logic [2:0]    bidx;
    logic [7:0]    sh;
    logic          rx_s;
    logic          fall;
    logic          vote;

    assign rx_s = sync[1];
    assign fall = sync[2] && !sync[1];
    assign vote = maj3(samp[1], samp[0], rx_s);
    assign data = sh;

    // Two-flop synchronizer plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 3'b111;
        else        sync <= {sync[1:0], rxd};
    end

    // Frame state machine, sampling and byte assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            tcnt  <= '0;
            samp  <= '0;
            bidx  <= '0;
            sh    <= '0;
            push  <= 1'b0;
        end else begin
            push <= 1'b0;
            if (state == RX_IDLE) begin
                if (rxen && fall) begin
                    state <= RX_START;
                    tcnt  <= '0;
                end
            end else if (tick) begin
                tcnt <= (tcnt == TW'(OSR-1)) ? '0 : tcnt + 1'b1;
                if (tcnt == TW'(MID-1)) samp[1] <= rx_s;
                if (tcnt == TW'(MID))   samp[0] <= rx_s;
                if (tcnt == TW'(MID+1)) begin
                    case (state)
                        RX_START: if (vote) state <= RX_IDLE;
                        RX_DATA:  sh <= {vote, sh[7:1]};
                        RX_STOP: begin
                            push  <= vote;
                            state <= RX_IDLE;
                        end
                        default: state <= RX_IDLE;
                    endcase
                end
                if (tcnt == TW'(OSR-1)) begin
                    if (state == RX_START) begin
                        state <= RX_DATA;
                        bidx  <= '0;
                    end else if (state == RX_DATA) begin
                        if (bidx == 3'd7) state <= RX_STOP;
                        else              bidx  <= bidx + 1'b1;
                    end
                end
            end
        end
    end

    // R7: each frame queues at most one byte.
    a_r7_single_push: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    // R7: a byte is only queued after the stop-bit decision.
    a_r7_push_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ($past(state) == RX_STOP));

endmodule

// File: rtl/mmio_uart.sv
// Module: mmio_uart (top)
// Register file, both queues, the shared oversampling tick, serializer,
// deserializer and watermark interrupt logic.
// Assumes: one bus access per asserted bus_en cycle, with read data taken
// combinationally in that cycle. A read of receive data removes a byte.
module mmio_uart
    import mmio_uart_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV_W = 16,
    parameter int OSR   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        serial_rx,
    output logic        serial_tx,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    reg_sel_e          sel;
    logic              wr_acc;
    logic              rd_acc;
    logic              txen;
    logic              two_stop;
    logic [WM_W-1:0]   txwm;
    logic              rxen;
    logic [WM_W-1:0]   rxwm;
    logic [1:0]        ie;
    logic [1:0]        ip;
    logic [DIV_W-1:0]  div;
    logic [DIV_W-1:0]  pcnt;
    logic              tick;

    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic [7:0]        tx_dout;
    logic [CW-1:0]     tx_count;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [7:0]        rx_din, rx_dout;
    logic [CW-1:0]     rx_count;
    logic              unused_bits;

    assign sel    = reg_sel_e'(bus_addr[4:2]);
    assign wr_acc = bus_en && bus_we;
    assign rd_acc = bus_en && !bus_we;

    assign tx_push = wr_acc && (sel == REG_TXDATA);
    assign rx_pop  = rd_acc && (sel == REG_RXDATA) && !rx_empty;

    assign ip[0] = tx_count < CW'(txwm);
    assign ip[1] = rx_count > CW'(rxwm);
    assign irq   = |(ip & ie);

    assign unused_bits = ^{bus_wdata[31:19], bus_addr[1:0], rx_full};

    // Writable control registers; the pending register has no storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txen     <= 1'b0;
            two_stop <= 1'b0;
            txwm     <= '0;
            rxen     <= 1'b0;
            rxwm     <= '0;
            ie       <= '0;
            div      <= '0;
        end else if (wr_acc) begin
            case (sel)
                REG_TXCTRL: begin
                    txen     <= bus_wdata[0];
                    two_stop <= bus_wdata[1];
                    txwm     <= bus_wdata[WM_LSB +: WM_W];
                end
                REG_RXCTRL: begin
                    rxen <= bus_wdata[0];
                    rxwm <= bus_wdata[WM_LSB +: WM_W];
                end
                REG_IE:  ie  <= bus_wdata[1:0];
                REG_DIV: div <= bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    // Oversampling tick: one pulse every div+1 cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) pcnt <= '0;
        else        pcnt <= tick ? '0 : pcnt + 1'b1;
    end
    assign tick = (pcnt >= div);

    // Read data multiplexer.
    always_comb begin
        case (sel)
            REG_TXDATA: bus_rdata = {tx_full, 31'b0};
            REG_RXDATA: bus_rdata = rx_empty ? 32'h8000_0000 : {24'b0, rx_dout};
            REG_TXCTRL: bus_rdata = {13'b0, txwm, 14'b0, two_stop, txen};
            REG_RXCTRL: bus_rdata = {13'b0, rxwm, 15'b0, rxen};
            REG_IE:     bus_rdata = {30'b0, ie};
            REG_IP:     bus_rdata = {30'b0, ip};
            REG_DIV:    bus_rdata = 32'(div);
            default:    bus_rdata = '0;
        endcase
    end

    uart_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .din(bus_wdata[7:0]), .dout(tx_dout), .full(tx_full),
        .empty(tx_empty), .count(tx_count)
    );

    uart_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .din(rx_din), .dout(rx_dout), .full(rx_full),
        .empty(rx_empty), .count(rx_count)
    );

    uart_tx_ser #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .txen(txen),
        .two_stop(two_stop), .fifo_empty(tx_empty), .fifo_data(tx_dout),
        .fifo_pop(tx_pop), .txd(serial_tx)
    );

    uart_rx_des #(.OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxen(rxen),
        .rxd(serial_rx), .push(rx_push), .data(rx_din)
    );

    // R11: with every mask bit clear the interrupt stays low.
    a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 2'b00) |-> !irq);

    // R4: the receive queue is only drained by a receive-data read.
    a_r4_pop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_acc && !rx_push) |=> (rx_count == $past(rx_count)));

endmodule

// File: tb/mmio_uart_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected transmit frames, and a line
// monitor decodes serial_tx, pops the queue and compares.
module mmio_uart_test;
    localparam int T = 32;  // bit time with divisor 1: 16 ticks x 2 cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        serial_rx = 1'b1;
    logic        serial_tx;
    logic        irq;

    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    int   frames = 0;
    bit   mon_busy = 1'b0;
    logic [7:0] exp_q[$];
    bit         exp_stop2[$];

    mmio_uart uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .serial_rx(serial_rx), .serial_tx(serial_tx), .irq(irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input bit good_stop);
        @(negedge clk);
        serial_rx = 1'b0;
        repeat (T) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            serial_rx = b[i];
            repeat (T) @(negedge clk);
        end
        serial_rx = good_stop;
        repeat (T) @(negedge clk);
        serial_rx = 1'b1;
        repeat (2*T) @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (12*T) @(negedge clk);
    endtask

    // Line monitor: decodes frames and checks data, stop bits and spacing (R5).
    initial begin : monitor
        logic       prev;
        logic [7:0] got;
        int         last_edge;
        bit         last_stop2;
        bit         have_last;
        prev = 1'b1;
        have_last = 1'b0;
        last_edge = 0;
        last_stop2 = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !serial_tx) begin
                int  edge_c;
                bit  s2;
                logic [7:0] e;
                mon_busy = 1'b1;
                edge_c = cyc;
                if (have_last && (edge_c - last_edge) < 12*T) begin
                    int expgap, gap;
                    expgap = (last_stop2 ? 11 : 10) * T;
                    gap = edge_c - last_edge;
                    chk(gap >= expgap - 3 && gap <= expgap + 3,
                        "R5 frame spacing", gap, expgap);
                end
                repeat (T/2) @(negedge clk);
                chk(serial_tx == 1'b0, "R5 start bit", serial_tx, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (T) @(negedge clk);
                    got[i] = serial_tx;
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R6 unexpected frame", got, 0);
                    s2 = 1'b0;
                end else begin
                    e  = exp_q.pop_front();
                    s2 = exp_stop2.pop_front();
                    chk(got == e, "R5 frame data", got, e);
                end
                repeat (T) @(negedge clk);
                chk(serial_tx == 1'b1, "R5 stop bit 1", serial_tx, 1);
                if (s2) begin
                    repeat (T) @(negedge clk);
                    chk(serial_tx == 1'b1, "R5 stop bit 2", serial_tx, 1);
                end
                frames++;
                have_last = 1'b1;
                last_edge = edge_c;
                last_stop2 = s2;
                mon_busy = 1'b0;
            end
            prev = serial_tx;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : driver
        logic [31:0] d;
        int f0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(serial_tx == 1'b1, "R1 tx idle", serial_tx, 1);
        chk(irq == 1'b0, "R1 irq low", irq, 0);
        rd(5'h04, d); chk(d[31] == 1'b1, "R1 rx empty flag", d, 32'h8000_0000);
        rd(5'h00, d); chk(d == 0, "R1 txdata", d, 0);
        rd(5'h08, d); chk(d == 0, "R1 txctrl", d, 0);
        rd(5'h14, d); chk(d == 0, "R1 pending", d, 0);
        rd(5'h18, d); chk(d == 0, "R1 divisor", d, 0);

        // R2 register map readback
        wr(5'h18, 32'd1);
        wr(5'h08, 32'h0001_0000);
        wr(5'h0C, 32'h0002_0000);
        wr(5'h10, 32'd0);
        rd(5'h08, d); chk(d == 32'h0001_0000, "R2 txctrl", d, 32'h0001_0000);
        rd(5'h0C, d); chk(d == 32'h0002_0000, "R2 rxctrl", d, 32'h0002_0000);
        rd(5'h18, d); chk(d == 32'd1, "R2 divisor", d, 1);
        rd(5'h10, d); chk(d == 32'd0, "R2 enable mask", d, 0);

        // R9 empty queue below threshold 1; R11 masking and read-only pending
        rd(5'h14, d); chk(d[0] == 1'b1, "R9 tx empty pending", d, 1);
        chk(irq == 1'b0, "R11 masked", irq, 0);
        wr(5'h10, 32'd1);
        chk(irq == 1'b1, "R11 enabled tx irq", irq, 1);
        wr(5'h14, 32'd0);
        rd(5'h14, d); chk(d[0] == 1'b1, "R11 pending write ignored", d, 1);
        wr(5'h10, 32'd0);

        // R3 fill the transmit queue while disabled
        for (int i = 0; i < 8; i++) wr(5'h00, 32'hA0 + i);
        rd(5'h00, d); chk(d[31] == 1'b1, "R3 full flag", d, 32'h8000_0000);
        rd(5'h14, d); chk(d[0] == 1'b0, "R9 tx occupied", d, 0);
        wr(5'h00, 32'hEE);
        repeat (4*T) @(negedge clk);
        chk(frames == 0, "R6 disabled no frame", frames, 0);
        chk(serial_tx == 1'b1, "R6 line idle", serial_tx, 1);

        // R5 one stop bit, back-to-back frames
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(8'hA0 + 8'(i));
            exp_stop2.push_back(1'b0);
        end
        wr(5'h08, 32'h0001_0001);
        drain();
        chk(frames == 8, "R3 full write dropped", frames, 8);
        rd(5'h14, d); chk(d[0] == 1'b1, "R9 drained", d, 1);

        // R5 two stop bits
        exp_q.push_back(8'h3C); exp_stop2.push_back(1'b1);
        exp_q.push_back(8'hC3); exp_stop2.push_back(1'b1);
        wr(5'h08, 32'h0001_0003);
        wr(5'h00, 32'h3C);
        wr(5'h00, 32'hC3);
        drain();

        // R6 clearing enable mid-frame
        f0 = frames;
        exp_q.push_back(8'h55); exp_stop2.push_back(1'b1);
        wr(5'h00, 32'h55);
        wr(5'h00, 32'h66);
        while (!mon_busy) @(negedge clk);
        wr(5'h08, 32'h0001_0002);
        repeat (24*T) @(negedge clk);
        chk(frames == f0 + 1, "R6 in-flight frame finished", frames, f0 + 1);
        chk(serial_tx == 1'b1, "R6 idle after disable", serial_tx, 1);
        rd(5'h14, d); chk(d[0] == 1'b0, "R6 byte held", d, 0);
        exp_q.push_back(8'h66); exp_stop2.push_back(1'b1);
        wr(5'h08, 32'h0001_0003);
        drain();
        chk(frames == f0 + 2, "R6 resumed", frames, f0 + 2);

        // R7 receiver disabled
        send_rx(8'h11, 1'b1);
        rd(5'h04, d); chk(d[31] == 1'b1, "R7 disabled ignores", d, 32'h8000_0000);

        // R4 / R10 single byte with threshold 0
        wr(5'h0C, 32'h0000_0001);
        send_rx(8'h5A, 1'b1);
        rd(5'h14, d); chk(d[1] == 1'b1, "R10 above threshold 0", d, 2);
        rd(5'h04, d); chk(d == 32'h5A, "R4 R7 byte received", d, 32'h5A);
        rd(5'h04, d); chk(d[31] == 1'b1, "R4 empty after pop", d, 32'h8000_0000);
        rd(5'h14, d); chk(d[1] == 1'b0, "R10 equal not above", d, 0);

        // R7 bad stop bit dropped
        send_rx(8'h77, 1'b0);
        rd(5'h04, d); chk(d[31] == 1'b1, "R7 bad stop dropped", d, 32'h8000_0000);

        // R10 threshold 2
        wr(5'h0C, 32'h0002_0001);
        send_rx(8'h01, 1'b1);
        send_rx(8'h02, 1'b1);
        rd(5'h14, d); chk(d[1] == 1'b0, "R10 count equals threshold", d, 0);
        send_rx(8'h03, 1'b1);
        rd(5'h14, d); chk(d[1] == 1'b1, "R10 count above threshold", d, 2);
        wr(5'h10, 32'd2);
        chk(irq == 1'b1, "R11 rx irq", irq, 1);
        wr(5'h10, 32'd0);

        // R8 overflow drop
        for (int i = 4; i <= 8; i++) send_rx(8'(i), 1'b1);
        send_rx(8'h99, 1'b1);
        for (int i = 1; i <= 8; i++) begin
            rd(5'h04, d); chk(d == 32'(i), "R8 order kept", d, 32'(i));
        end
        rd(5'h04, d); chk(d[31] == 1'b1, "R8 overflow byte dropped", d, 32'h8000_0000);

        chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule